// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash interface and takes over once a program or erase command has been sent. It tells whether the embedded operation has finished by reading the device status byte in back-to-back pairs. It compares the toggle bit between the two reads of each pair. A toggle bit that holds still means the device has finished. A toggle bit that keeps changing while the timeout flag is set is checked with one more pair of reads before the block declares a failure.

The host starts a run with a one-cycle `start` pulse. The block issues one-cycle read strobes on a request/response read port and waits for each response before it sends the next strobe. The run ends with a one-cycle `done` pulse or a one-cycle `fail` pulse. Before it reports a failure, the block writes the return-to-read command to the flash with a single one-cycle write strobe. A poll budget stops the run with a failure if the device never settles.

Top module: `toggle_poller`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `fail`, `rd_req` and `wr_req` are all 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. A `start` pulse while `busy` is 1 is ignored: it causes no extra reads and no extra result.
- R3: Each polling step issues exactly two read strobes, each one cycle wide. The second strobe comes only after the response to the first has arrived (`rd_valid`).
- R4: When bit 6 of the status byte is equal in both reads of a step, the run ends with `done` and no write is issued.
- R5: When bit 6 differs and bit 5 of the second read is 0, another step of two reads follows.
- R6: When bit 6 differs and bit 5 of the second read is 1, exactly one confirming pair of reads follows. If bit 6 is equal in that pair, the run ends with `done`.
- R7: When bit 6 still differs in the confirming pair, the block issues one write of 0xF0 to address 0 with a one-cycle `wr_req`. `fail` pulses on the following cycle.
- R8: After `MAX_POLLS` toggling steps in which bit 5 stays 0, the run ends with the same reset write and `fail`, and no further reads are issued.
- R9: `done` and `fail` are each one cycle wide and are never high together. `busy` is 0 in the cycle where either one is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle pulse: the operation completed |
| fail | output | 1 | One-cycle pulse: the operation failed or the budget ran out |
| rd_req | output | 1 | One-cycle status read strobe |
| rd_valid | input | 1 | Status read response is valid |
| rd_data | input | DATA_W | Status byte returned by the read |
| wr_req | output | 1 | One-cycle command write strobe |
| wr_addr | output | ADDR_W | Command write address (always 0) |
| wr_data | output | DATA_W | Command write data (0xF0) |

## Verification
A behavioural flash model makes bit 6 toggle on every read for a chosen number of reads and then hold. It raises bit 5 from a chosen read onward. Devices that are already idle, that settle after one or several steps, and that settle exactly on the last allowed step separate the plain completion path from the budget limit. Cases where bit 5 rises and the device then either settles or keeps toggling in the confirming pair separate the confirmed completion from a real failure. For every run the bench counts reads and writes, so an extra or missing pair is caught along with the result. A `start` pulse sent in the middle of a run shows that a second start is ignored.

// File: rtl/toggle_poller_pkg.sv
// Package: shared state encodings for the toggle-bit poller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package toggle_poller_pkg;

    // Read-pair sequencer states
    typedef enum logic [2:0] {
        RP_IDLE  = 3'd0,
        RP_REQ1  = 3'd1,
        RP_WAIT1 = 3'd2,
        RP_REQ2  = 3'd3,
        RP_WAIT2 = 3'd4
    } rp_state_t;

    // Top-level decision states
    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_POLL    = 2'd1,
        PS_CONFIRM = 2'd2,
        PS_RSTWR   = 2'd3
    } ps_state_t;

endpackage

// File: rtl/poll_read_pair.sv
// Module: poll_read_pair
// Issues two status reads in turn on a request/response port. When the second
// response arrives, it reports whether the toggle bit differed and the value
// of the timeout flag in the second read.
// Assumes: each response arrives at least one cycle after its strobe, and a
// new go pulse comes only after pair_done.
module poll_read_pair
    import toggle_poller_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int TOGGLE_BIT = 6,
    parameter int LIMIT_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              pair_done,
    output logic              toggled,
    output logic              limit_seen
);

    rp_state_t st;
    logic      first_tog;

    // Strobe only in the two request states
    assign rd_req = (st == RP_REQ1) || (st == RP_REQ2);

    // Sequence both reads and capture the comparison result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= RP_IDLE;
            first_tog  <= 1'b0;
            pair_done  <= 1'b0;
            toggled    <= 1'b0;
            limit_seen <= 1'b0;
        end else begin
            pair_done <= 1'b0;
            unique case (st)
                RP_IDLE:  if (go) st <= RP_REQ1;
                RP_REQ1:  st <= RP_WAIT1;
                RP_WAIT1: if (rd_valid) begin
                    first_tog <= rd_data[TOGGLE_BIT];
                    st        <= RP_REQ2;
                end
                RP_REQ2:  st <= RP_WAIT2;
                RP_WAIT2: if (rd_valid) begin
                    toggled    <= first_tog ^ rd_data[TOGGLE_BIT];
                    limit_seen <= rd_data[LIMIT_BIT];
                    pair_done  <= 1'b1;
                    st         <= RP_IDLE;
                end
                default:  st <= RP_IDLE;
            endcase
        end
    end

    // R3: a read strobe never lasts two cycles
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R3: a pair result arrives only after a response
    a_r3_result_after_response: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |-> $past(rd_valid));

endmodule

// File: rtl/poll_budget.sv
// Module: poll_budget
// Counts the toggling steps in which the timeout flag stayed clear, and flags
// when the next such step would be the last one allowed.
// Assumes: MAX_POLLS >= 1, and inc is not asserted once last is high.
module poll_budget #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_W'(MAX_POLLS - 1));

    // Clear at run start; count one per non-final toggling step
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // R8: the count stays below the budget
    a_r8_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAX_POLLS));

endmodule

// File: rtl/toggle_poller.sv
// Module: toggle_poller (top)
// After a program or erase command, this module polls the flash status in
// pairs of reads until the toggle bit holds still (done) or the operation
// fails. On failure it writes the reset command and then pulses fail.
// Assumes: the command itself was issued elsewhere before start.
module toggle_poller
    import toggle_poller_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          ADDR_W     = 18,
    parameter int          MAX_POLLS  = 4096,
    parameter int          TOGGLE_BIT = 6,
    parameter int          LIMIT_BIT  = 5,
    parameter logic [7:0]  RESET_CMD  = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    ps_state_t st;
    logic      go;
    logic      pair_done;
    logic      toggled;
    logic      limit_seen;
    logic      budget_clr;
    logic      budget_inc;
    logic      budget_last;

    assign busy    = (st != PS_IDLE);
    assign wr_addr = '0;
    assign wr_data = DATA_W'(RESET_CMD);

    poll_read_pair #(
        .DATA_W     (DATA_W),
        .TOGGLE_BIT (TOGGLE_BIT),
        .LIMIT_BIT  (LIMIT_BIT)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .rd_req     (rd_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .pair_done  (pair_done),
        .toggled    (toggled),
        .limit_seen (limit_seen)
    );

    // Budget is cleared on accept and advanced on each plain toggling step
    assign budget_clr = (st == PS_IDLE) && start;
    assign budget_inc = (st == PS_POLL) && pair_done && toggled
                        && !limit_seen && !budget_last;

    poll_budget #(
        .MAX_POLLS (MAX_POLLS)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (budget_clr),
        .inc   (budget_inc),
        .last  (budget_last)
    );

    // Decide the next step from each finished read pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= PS_IDLE;
            go     <= 1'b0;
            done   <= 1'b0;
            fail   <= 1'b0;
            wr_req <= 1'b0;
        end else begin
            go     <= 1'b0;
            done   <= 1'b0;
            fail   <= 1'b0;
            wr_req <= 1'b0;
            unique case (st)
                PS_IDLE: if (start) begin
                    go <= 1'b1;
                    st <= PS_POLL;
                end
                PS_POLL: if (pair_done) begin
                    if (!toggled) begin
                        done <= 1'b1;
                        st   <= PS_IDLE;
                    end else if (limit_seen) begin
                        go <= 1'b1;
                        st <= PS_CONFIRM;
                    end else if (budget_last) begin
                        wr_req <= 1'b1;
                        st     <= PS_RSTWR;
                    end else begin
                        go <= 1'b1;
                    end
                end
                PS_CONFIRM: if (pair_done) begin
                    if (!toggled) begin
                        done <= 1'b1;
                        st   <= PS_IDLE;
                    end else begin
                        wr_req <= 1'b1;
                        st     <= PS_RSTWR;
                    end
                end
                PS_RSTWR: begin
                    fail <= 1'b1;
                    st   <= PS_IDLE;
                end
                default: st <= PS_IDLE;
            endcase
        end
    end

    // R9: results are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: fail follows the reset write by one cycle
    a_r7_write_then_fail: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(wr_req));

    // R2: reads happen only inside a run
    a_r2_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    // R2: an idle start is accepted on the next cycle
    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: tb/toggle_poller_test.sv
module toggle_poller_test;

    localparam int MAXP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, fail, rd_req, wr_req;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [17:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;

    // Device model settings and observations
    int dev_t = 0;
    int dev_l = 1000;
    int nreads = 0;
    int nwrites = 0;
    logic [7:0]  last_wdata = 8'h00;
    logic [17:0] last_waddr = '1;

    always #10 clk = ~clk;

    toggle_poller #(.MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] dev_status(int i);
        logic [7:0] s;
        s    = 8'h00;
        s[6] = (i < dev_t) ? i[0] : dev_t[0];
        s[5] = (i >= dev_l);
        return s;
    endfunction

    // Flash model: answer each read strobe one cycle later, log writes
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req) begin
            rd_valid <= 1'b1;
            rd_data  <= dev_status(nreads);
            nreads   <= nreads + 1;
        end
        if (wr_req) begin
            nwrites    <= nwrites + 1;
            last_wdata <= wr_data;
            last_waddr <= wr_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // toggle reads, limit read index, expect fail, expected reads
    typedef struct packed {
        logic [15:0] t;
        logic [15:0] l;
        logic        efail;
        logic [7:0]  ereads;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   16'd999, 1'b0, 8'd2},   // R4 idle device
        '{16'd1,   16'd999, 1'b0, 8'd4},   // R5 one extra step
        '{16'd5,   16'd999, 1'b0, 8'd8},   // R5 several steps
        '{16'd4,   16'd3,   1'b0, 8'd6},   // R6 confirm settles
        '{16'd6,   16'd3,   1'b1, 8'd6},   // R7 confirm still toggles
        '{16'd3,   16'd0,   1'b1, 8'd4},   // R7 limit on first pair
        '{16'd10,  16'd999, 1'b0, 8'd12},  // R8 settles on last allowed step
        '{16'd11,  16'd999, 1'b1, 8'd12},  // R8 budget exhausted
        '{16'd200, 16'd999, 1'b1, 8'd12}   // R8 never settles
    };

    int  got_fail;
    int  pulse_w;
    int  timeout;

    task automatic run(input int t, input int l, input bit mid_start);
        dev_t = t;
        dev_l = l;
        @(negedge clk);
        nreads  = 0;
        nwrites = 0;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2 busy after start", busy, 1);
        timeout  = 0;
        got_fail = -1;
        while (!(done || fail) && timeout < 2000) begin
            if (mid_start && timeout == 5) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            timeout++;
        end
        start = 1'b0;
        check(timeout < 2000, "R9 run ends (watchdog)", timeout, 0);
        if (timeout < 2000) begin
            got_fail = fail ? 1 : 0;
            check(!(done && fail), "R9 exclusive", done & fail, 0);
            check(busy === 1'b0, "R9 busy low at result", busy, 0);
            @(negedge clk);
            check(!done && !fail, "R9 one-cycle result", done | fail, 0);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({busy, done, fail, rd_req, wr_req} === 5'b0, "R1 during reset",
              {busy, done, fail, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({busy, done, fail, rd_req, wr_req} === 5'b0, "R1 after reset",
              {busy, done, fail, rd_req, wr_req}, 0);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run(int'(VECS[i].t), int'(VECS[i].l), 1'b0);
            check(got_fail == int'(VECS[i].efail), "R4/R6/R7/R8 result",
                  got_fail, int'(VECS[i].efail));
            check(nreads == int'(VECS[i].ereads), "R3/R5 read count",
                  nreads, int'(VECS[i].ereads));
            check(nwrites == (VECS[i].efail ? 1 : 0), "R7 write count",
                  nwrites, VECS[i].efail ? 1 : 0);
            if (VECS[i].efail) begin
                check(last_wdata == 8'hF0, "R7 write data", last_wdata, 8'hF0);
                check(last_waddr == '0, "R7 write address", last_waddr, 0);
            end
        end

        // R2: a start during a run is ignored
        run(200, 999, 1'b1);
        check(got_fail == 1, "R2 ignored start result", got_fail, 1);
        check(nreads == 12, "R2 ignored start reads", nreads, 12);
        check(nwrites == 1, "R2 ignored start writes", nwrites, 1);
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && nreads == 12, "R2 no run after ignored start",
              nreads, 12);

        // R1: reset in the middle of a run clears everything
        dev_t = 200; dev_l = 999;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check({busy, done, fail, rd_req, wr_req} === 5'b0, "R1 mid-run reset",
              {busy, done, fail, rd_req, wr_req}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule